// File: doc/BRIEF.md
# Vector Configuration Setting Unit

This block carries out the three vector configuration instructions of a vector pipeline. In the first form, the vector type comes from the immediate and the requested length comes from a scalar register. In the second form, both come from scalar registers. In the third form, the vector type comes from the immediate and the requested length is a 5-bit immediate. The pipeline presents a decoded 32-bit instruction word with a valid strobe, together with the two scalar source values. The block checks that the encoding belongs to the family. It then decides whether the requested element width and group multiplier are legal, derives the largest vector length they allow, and updates its vector-type and vector-length registers in one step.

Besides the two architectural registers, the block returns a one-cycle destination-register write (index, value, enable) and a one-cycle pulse that tells the vector unit to clear its start index. Vector register width and maximum element width are parameters given as base-2 logarithms. The largest length is therefore formed from shift amounts and no multiplier is needed.

Top module: `vcfg_unit`

## Requirements
- R1: `match_o` is high, combinationally, exactly when instr[6:0] = 1010111, instr[14:12] = 111, and either instr[31] = 0 (immediate type, register length), instr[31:25] = 1000000 (register type, register length), or instr[31:30] = 11 (immediate type, immediate length).
- R2: During and after synchronous reset (`rst_n` low), `vtype_o` holds only its MSB (illegal flag) set, `vl_o` = 0, and `rd_we_o` and `vstart_clr_o` are low.
- R3: The type byte is {ma[7], ta[6], sew[5:3], lmul[2:0]}. For both immediate forms it is taken from instr[27:20]; for the register form it is taken from rs2[7:0]. A legal new `vtype_o` is that byte zero-extended, with the MSB clear.
- R4: sew codes 000/001/010/011 mean 8/16/32/64 bits. lmul codes 101/110/111/000/001/010/011 mean 1/8, 1/4, 1/2, 1, 2, 4, 8, read as a signed log2. VLMAX = 2^(VLEN_LOG2 + lmul_log2 - sew_log2), so `vl_o` never exceeds 2^VLEN_LOG2.
- R5: A setting is illegal when sew is 1xx, when lmul is 100, when sew_log2 > lmul_log2 + ELEN_LOG2, or when a reserved bit is set. The reserved bits are instr[30:28] for the first form, instr[29:28] for the immediate-length form, and rs2[XLEN-1:8] for the register form. An illegal setting writes `vtype_o` with only the MSB set and `vl_o` = 0. It gives no rd write and no start-clear pulse.
- R6: In the register-length forms with rs1 index (instr[19:15]) nonzero, AVL is the rs1 value. The new vl is AVL when AVL ≤ VLMAX, (AVL+1)/2 when VLMAX < AVL < 2·VLMAX, and VLMAX otherwise.
- R7: In the register-length forms with rs1 index 0 and rd index (instr[11:7]) nonzero, the new vl is VLMAX.
- R8: In the register-length forms with both the rs1 and rd indices 0, vl is kept when sew_log2 − lmul_log2 equals that of the current type. If the ratio differs, or the current type is illegal, the result is the illegal type with vl = 0 and the start-clear pulse is still given.
- R9: In the immediate-length form, AVL is instr[19:15] zero-extended (0 included), and the rule of R6 applies.
- R10: One cycle after an accepted legal operation that sets a length (R6, R7, R9) with rd index nonzero, `rd_we_o` pulses for one cycle with `rd_idx_o` = rd and `rd_data_o` = the new `vl_o`. There is no write in any other case.
- R11: One cycle after every accepted operation except an illegal setting, `vstart_clr_o` pulses for one cycle.
- R12: When `valid_i` is low or `match_o` is low, `vtype_o` and `vl_o` keep their values and neither pulse is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| valid_i | input | 1 | Instruction strobe |
| instr_i | input | 32 | Instruction word |
| rs1_val_i | input | XLEN | Value of scalar source 1 |
| rs2_val_i | input | XLEN | Value of scalar source 2 |
| match_o | output | 1 | Encoding belongs to the family |
| vtype_o | output | XLEN | Vector type register |
| vl_o | output | XLEN | Vector length register |
| rd_we_o | output | 1 | Destination write pulse |
| rd_idx_o | output | 5 | Destination index |
| rd_data_o | output | XLEN | Destination write value |
| vstart_clr_o | output | 1 | Start-index clear pulse |

## Verification
The bench uses the default build: XLEN = 32, VLEN_LOG2 = 7 and ELEN_LOG2 = 6. With these values VLMAX ranges from 2 (8-bit elements at 1/8 grouping, or 64-bit elements at grouping 1) up to 128. Because small AVL values straddle the halving window, each branch of the length rule can be reached with 5-bit immediates. Because ELEN is one step below VLEN, the width-versus-grouping limit can be exercised with settings such as 64-bit elements at 1/2 grouping and 32-bit elements at 1/8 grouping.

// File: rtl/vcfg_pkg.sv
package vcfg_pkg;

  typedef enum logic [1:0] {
    FORM_NONE,
    FORM_REG_AVL_IMM_VT,
    FORM_REG_AVL_REG_VT,
    FORM_IMM_AVL_IMM_VT
  } vcfg_form_e;

  typedef struct packed {
    logic       ma;
    logic       ta;
    logic [2:0] sew;
    logic [2:0] lmul;
  } vt_byte_t;

  localparam logic [6:0] OPC_VEC = 7'b1010111;
  localparam logic [2:0] F3_CFG  = 3'b111;

  // log2 of the element width in bits; only codes 0xx are meaningful
  function automatic int sew_log2(input logic [2:0] code);
    return 3 + int'(code[1:0]);
  endfunction

  // log2 of the grouping multiplier: the code taken as a signed value
  function automatic int lmul_log2(input logic [2:0] code);
    return int'($signed(code));
  endfunction

  function automatic int ratio_log2(input logic [2:0] sew, input logic [2:0] lmul);
    return sew_log2(sew) - lmul_log2(lmul);
  endfunction

  function automatic int vlmax_log2(input int vlen_log2, input logic [2:0] sew,
                                    input logic [2:0] lmul);
    return vlen_log2 + lmul_log2(lmul) - sew_log2(sew);
  endfunction

endpackage

// File: rtl/vcfg_decode.sv
module vcfg_decode
  import vcfg_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [31:0]     instr_i,
  input  logic [XLEN-1:0] rs2_val_i,
  output logic            match_o,
  output vcfg_form_e      form_o,
  output vt_byte_t        vt_o,
  output logic            resv_nz_o,
  output logic [4:0]      rd_o,
  output logic [4:0]      rs1f_o
);

  logic fam;

  always_comb begin
    fam    = (instr_i[6:0] == OPC_VEC) && (instr_i[14:12] == F3_CFG);
    form_o = FORM_NONE;
    if (fam) begin
      if (!instr_i[31])                     form_o = FORM_REG_AVL_IMM_VT;
      else if (instr_i[31:25] == 7'b1000000) form_o = FORM_REG_AVL_REG_VT;
      else if (instr_i[31:30] == 2'b11)     form_o = FORM_IMM_AVL_IMM_VT;
    end
    match_o = (form_o != FORM_NONE);
  end

  always_comb begin
    rd_o   = instr_i[11:7];
    rs1f_o = instr_i[19:15];
    unique case (form_o)
      FORM_REG_AVL_REG_VT: begin
        vt_o      = vt_byte_t'(rs2_val_i[7:0]);
        resv_nz_o = |rs2_val_i[XLEN-1:8];
      end
      FORM_IMM_AVL_IMM_VT: begin
        vt_o      = vt_byte_t'(instr_i[27:20]);
        resv_nz_o = |instr_i[29:28];
      end
      default: begin
        vt_o      = vt_byte_t'(instr_i[27:20]);
        resv_nz_o = |instr_i[30:28];
      end
    endcase
  end

endmodule

// File: rtl/vcfg_legal.sv
module vcfg_legal
  import vcfg_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int VLEN_LOG2 = 7,
  parameter int ELEN_LOG2 = 6
) (
  input  vt_byte_t        vt_i,
  input  logic            resv_nz_i,
  input  logic            cur_vill_i,
  input  logic [5:0]      cur_code_i,
  output logic            cfg_ok_o,
  output logic            ratio_same_o,
  output logic [XLEN-1:0] vlmax_o
);

  localparam logic [XLEN-1:0] ONE = XLEN'(1);

  int shamt;

  always_comb begin
    cfg_ok_o = !resv_nz_i && !vt_i.sew[2] && (vt_i.lmul != 3'b100) &&
               (sew_log2(vt_i.sew) <= lmul_log2(vt_i.lmul) + ELEN_LOG2);
    shamt    = cfg_ok_o ? vlmax_log2(VLEN_LOG2, vt_i.sew, vt_i.lmul) : 0;
    vlmax_o  = cfg_ok_o ? (ONE << shamt) : '0;
    ratio_same_o = !cur_vill_i &&
                   (ratio_log2(vt_i.sew, vt_i.lmul) ==
                    ratio_log2(cur_code_i[5:3], cur_code_i[2:0]));
  end

endmodule

// File: rtl/vcfg_avl.sv
module vcfg_avl #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] avl_i,
  input  logic [XLEN-1:0] vlmax_i,
  output logic [XLEN-1:0] vl_o
);

  logic [XLEN-1:0] twice;

  always_comb begin
    twice = vlmax_i << 1;
    if (avl_i <= vlmax_i)   vl_o = avl_i;
    else if (avl_i < twice) vl_o = (avl_i + XLEN'(1)) >> 1;
    else                    vl_o = vlmax_i;
  end

endmodule

// File: rtl/vcfg_unit.sv
module vcfg_unit
  import vcfg_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int VLEN_LOG2 = 7,
  parameter int ELEN_LOG2 = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            valid_i,
  input  logic [31:0]     instr_i,
  input  logic [XLEN-1:0] rs1_val_i,
  input  logic [XLEN-1:0] rs2_val_i,
  output logic            match_o,
  output logic [XLEN-1:0] vtype_o,
  output logic [XLEN-1:0] vl_o,
  output logic            rd_we_o,
  output logic [4:0]      rd_idx_o,
  output logic [XLEN-1:0] rd_data_o,
  output logic            vstart_clr_o
);

  localparam logic [XLEN-1:0] VILL_WORD = {1'b1, {(XLEN-1){1'b0}}};

  vcfg_form_e      form;
  vt_byte_t        vt;
  logic            resv_nz;
  logic [4:0]      rd_f, rs1_f;
  logic            cfg_ok, ratio_same;
  logic [XLEN-1:0] vlmax, avl, avl_vl;

  logic [XLEN-1:0] vtype_q, vl_q, rd_data_q;
  logic            rd_we_q, clr_q;
  logic [4:0]      rd_idx_q;

  // events brought out for the checker
  logic acc_evt, bad_cfg_evt, keep_hold_evt;

  logic            use_avl, use_max, keep_req, keep_bad;
  logic [XLEN-1:0] vtype_n, vl_n;
  logic            we_n, clr_n;

  vcfg_decode #(.XLEN(XLEN)) u_dec (
    .instr_i   (instr_i),
    .rs2_val_i (rs2_val_i),
    .match_o   (match_o),
    .form_o    (form),
    .vt_o      (vt),
    .resv_nz_o (resv_nz),
    .rd_o      (rd_f),
    .rs1f_o    (rs1_f)
  );

  vcfg_legal #(.XLEN(XLEN), .VLEN_LOG2(VLEN_LOG2), .ELEN_LOG2(ELEN_LOG2)) u_legal (
    .vt_i         (vt),
    .resv_nz_i    (resv_nz),
    .cur_vill_i   (vtype_q[XLEN-1]),
    .cur_code_i   (vtype_q[5:0]),
    .cfg_ok_o     (cfg_ok),
    .ratio_same_o (ratio_same),
    .vlmax_o      (vlmax)
  );

  assign avl = (form == FORM_IMM_AVL_IMM_VT) ? XLEN'(rs1_f) : rs1_val_i;

  vcfg_avl #(.XLEN(XLEN)) u_avl (
    .avl_i   (avl),
    .vlmax_i (vlmax),
    .vl_o    (avl_vl)
  );

  always_comb begin
    use_avl  = (form == FORM_IMM_AVL_IMM_VT) || (rs1_f != 5'd0);
    use_max  = !use_avl && (rd_f != 5'd0);
    keep_req = !use_avl && (rd_f == 5'd0);
    keep_bad = keep_req && !ratio_same;

    if (!cfg_ok || keep_bad) begin
      vtype_n = VILL_WORD;
      vl_n    = '0;
    end else begin
      vtype_n = XLEN'(vt);
      if (use_avl)      vl_n = avl_vl;
      else if (use_max) vl_n = vlmax;
      else              vl_n = vl_q;
    end
    we_n  = cfg_ok && !keep_req && (rd_f != 5'd0);
    clr_n = cfg_ok;

    acc_evt       = valid_i && match_o;
    bad_cfg_evt   = !cfg_ok;
    keep_hold_evt = cfg_ok && keep_req && ratio_same;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vtype_q   <= VILL_WORD;
      vl_q      <= '0;
      rd_we_q   <= 1'b0;
      clr_q     <= 1'b0;
      rd_idx_q  <= '0;
      rd_data_q <= '0;
    end else begin
      rd_we_q <= acc_evt && we_n;
      clr_q   <= acc_evt && clr_n;
      if (acc_evt) begin
        vtype_q   <= vtype_n;
        vl_q      <= vl_n;
        rd_idx_q  <= rd_f;
        rd_data_q <= vl_n;
      end
    end
  end

  assign vtype_o      = vtype_q;
  assign vl_o         = vl_q;
  assign rd_we_o      = rd_we_q;
  assign rd_idx_o     = rd_idx_q;
  assign rd_data_o    = rd_data_q;
  assign vstart_clr_o = clr_q;

endmodule

// File: rtl/vcfg_unit_chk.sv
module vcfg_unit_chk #(
  parameter int XLEN      = 32,
  parameter int VLEN_LOG2 = 7
) (
  input logic            clk,
  input logic            rst_n,
  input logic            acc_evt,
  input logic            bad_cfg_evt,
  input logic            keep_hold_evt,
  input logic [XLEN-1:0] vtype_o,
  input logic [XLEN-1:0] vl_o,
  input logic            rd_we_o,
  input logic [XLEN-1:0] rd_data_o,
  input logic            vstart_clr_o
);

  localparam logic [XLEN-1:0] VL_CEIL   = XLEN'(1) << VLEN_LOG2;
  localparam logic [XLEN-1:0] VILL_WORD = {1'b1, {(XLEN-1){1'b0}}};

  assert_vill_zero_vl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    vtype_o[XLEN-1] |-> (vl_o == '0));

  assert_bad_cfg_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_evt && bad_cfg_evt) |=> (vtype_o == VILL_WORD) && !rd_we_o && !vstart_clr_o);

  assert_vl_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    vl_o <= VL_CEIL);

  assert_keep_vl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_evt && keep_hold_evt) |=> (vl_o == $past(vl_o)) && !rd_we_o);

  assert_rd_value_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_we_o |-> (rd_data_o == vl_o) && !vtype_o[XLEN-1]);

  assert_clr_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_evt && !bad_cfg_evt) |=> vstart_clr_o);

  assert_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_evt |=> $stable(vtype_o) && $stable(vl_o) && !rd_we_o && !vstart_clr_o);

endmodule

bind vcfg_unit vcfg_unit_chk #(.XLEN(XLEN), .VLEN_LOG2(VLEN_LOG2)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .acc_evt       (acc_evt),
  .bad_cfg_evt   (bad_cfg_evt),
  .keep_hold_evt (keep_hold_evt),
  .vtype_o       (vtype_o),
  .vl_o          (vl_o),
  .rd_we_o       (rd_we_o),
  .rd_data_o     (rd_data_o),
  .vstart_clr_o  (vstart_clr_o)
);

// File: tb/vcfg_unit_test.sv
module vcfg_unit_test;

  localparam int XLEN = 32;
  localparam logic [31:0] VILL = 32'h8000_0000;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            valid_i = 1'b0;
  logic [31:0]     instr_i = '0;
  logic [XLEN-1:0] rs1_val_i = '0;
  logic [XLEN-1:0] rs2_val_i = '0;
  logic            match_o;
  logic [XLEN-1:0] vtype_o, vl_o, rd_data_o;
  logic            rd_we_o, vstart_clr_o;
  logic [4:0]      rd_idx_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  vcfg_unit uut (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .instr_i(instr_i),
    .rs1_val_i(rs1_val_i), .rs2_val_i(rs2_val_i), .match_o(match_o),
    .vtype_o(vtype_o), .vl_o(vl_o), .rd_we_o(rd_we_o), .rd_idx_o(rd_idx_o),
    .rd_data_o(rd_data_o), .vstart_clr_o(vstart_clr_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] vtb(input bit ma, input bit ta, input logic [2:0] s,
                                     input logic [2:0] l);
    return {ma, ta, s, l};
  endfunction

  function automatic logic [31:0] enc_ri(input logic [4:0] rd, input logic [4:0] rs1,
                                         input logic [7:0] vt);
    return {4'b0000, vt, rs1, 3'b111, rd, 7'b1010111};
  endfunction

  function automatic logic [31:0] enc_rr(input logic [4:0] rd, input logic [4:0] rs1);
    return {7'b1000000, 5'd2, rs1, 3'b111, rd, 7'b1010111};
  endfunction

  function automatic logic [31:0] enc_ii(input logic [4:0] rd, input logic [4:0] uimm,
                                         input logic [7:0] vt);
    return {4'b1100, vt, uimm, 3'b111, rd, 7'b1010111};
  endfunction

  // drive one strobe; results are readable on return
  task automatic issue(input logic [31:0] ins, input logic [31:0] r1, input logic [31:0] r2);
    @(negedge clk);
    instr_i = ins; rs1_val_i = r1; rs2_val_i = r2; valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  task automatic expect_all(input string tag, input logic [31:0] vt, input logic [31:0] vl,
                            input logic we, input logic clr);
    chk({tag, " vtype"}, vtype_o, vt);
    chk({tag, " vl"}, vl_o, vl);
    chk({tag, " rd_we"}, 32'(rd_we_o), 32'(we));
    chk({tag, " vstart_clr"}, 32'(vstart_clr_o), 32'(clr));
  endtask

  task automatic t_reset;
    expect_all("R2 reset", VILL, 0, 1'b0, 1'b0);
  endtask

  task automatic t_decode;
    @(negedge clk);
    instr_i = enc_ri(5'd1, 5'd1, 8'h00); #1 chk("R1 match imm-vt", 32'(match_o), 1);
    instr_i = enc_rr(5'd1, 5'd1);        #1 chk("R1 match reg-vt", 32'(match_o), 1);
    instr_i = enc_ii(5'd1, 5'd1, 8'h00); #1 chk("R1 match imm-avl", 32'(match_o), 1);
    instr_i = enc_ri(5'd1, 5'd1, 8'h00) ^ 32'h1; #1 chk("R1 bad opcode", 32'(match_o), 0);
    instr_i = enc_ri(5'd1, 5'd1, 8'h00) & ~32'h1000; #1 chk("R1 bad funct3", 32'(match_o), 0);
    instr_i = enc_rr(5'd1, 5'd1) | 32'h0200_0000; #1 chk("R1 bad top bits", 32'(match_o), 0);
    issue(enc_rr(5'd1, 5'd1) | 32'h0200_0000, 32'd5, 32'h0);
    expect_all("R12 nonmatch", VILL, 0, 1'b0, 1'b0);
  endtask

  task automatic t_avl_rule;
    logic [31:0] avls [6] = '{10, 16, 17, 31, 32, 1000};
    logic [31:0] exps [6] = '{10, 16, 9, 16, 16, 16};
    for (int i = 0; i < 6; i++) begin
      issue(enc_ri(5'd5, 5'd1, vtb(1, 0, 3'b000, 3'b000)), avls[i], 32'h0);
      expect_all($sformatf("R6 avl=%0d", avls[i]), 32'h80, exps[i], 1'b1, 1'b1);
      chk("R10 rd_idx", 32'(rd_idx_o), 5);
      chk("R10 rd_data", rd_data_o, exps[i]);
    end
    issue(enc_ri(5'd0, 5'd1, 8'h00), 32'd7, 32'h0);
    expect_all("R10 rd zero no write", 32'h00, 7, 1'b0, 1'b1);
  endtask

  task automatic t_vlmax;
    issue(enc_ri(5'd3, 5'd0, vtb(0, 0, 3'b010, 3'b001)), 32'd99, 32'h0);
    expect_all("R7 e32 m2", 32'h11, 8, 1'b1, 1'b1);
    chk("R7 rd_data", rd_data_o, 8);
    issue(enc_ri(5'd3, 5'd0, vtb(0, 0, 3'b000, 3'b011)), 32'd0, 32'h0);
    expect_all("R4 e8 m8", 32'h03, 128, 1'b1, 1'b1);
    issue(enc_ri(5'd3, 5'd0, vtb(0, 0, 3'b000, 3'b101)), 32'd0, 32'h0);
    expect_all("R4 e8 mf8", 32'h05, 2, 1'b1, 1'b1);
    issue(enc_ri(5'd3, 5'd0, vtb(0, 1, 3'b011, 3'b000)), 32'd0, 32'h0);
    expect_all("R4 e64 m1", 32'h58, 2, 1'b1, 1'b1);
  endtask

  task automatic t_keep;
    issue(enc_ri(5'd4, 5'd1, 8'h00), 32'd10, 32'h0);
    expect_all("R8 setup", 32'h00, 10, 1'b1, 1'b1);
    issue(enc_ri(5'd0, 5'd0, vtb(0, 0, 3'b001, 3'b001)), 32'd77, 32'h0);
    expect_all("R8 same ratio keeps vl", 32'h09, 10, 1'b0, 1'b1);
    issue(enc_ri(5'd0, 5'd0, vtb(0, 0, 3'b010, 3'b001)), 32'd77, 32'h0);
    expect_all("R8 ratio change", VILL, 0, 1'b0, 1'b1);
    issue(enc_ri(5'd0, 5'd0, 8'h00), 32'd0, 32'h0);
    expect_all("R8 keep from illegal", VILL, 0, 1'b0, 1'b1);
  endtask

  task automatic t_illegal;
    issue(enc_ri(5'd4, 5'd1, 8'h00), 32'd6, 32'h0);
    expect_all("R5 setup", 32'h00, 6, 1'b1, 1'b1);
    issue(enc_ri(5'd4, 5'd1, vtb(0, 0, 3'b011, 3'b111)), 32'd6, 32'h0);
    expect_all("R5 e64 mf2", VILL, 0, 1'b0, 1'b0);
    issue(enc_ri(5'd4, 5'd1, 8'h00), 32'd6, 32'h0);
    issue(enc_ri(5'd4, 5'd1, vtb(0, 0, 3'b010, 3'b101)), 32'd6, 32'h0);
    expect_all("R5 e32 mf8", VILL, 0, 1'b0, 1'b0);
    issue(enc_ri(5'd4, 5'd1, vtb(0, 0, 3'b100, 3'b000)), 32'd6, 32'h0);
    expect_all("R5 sew 1xx", VILL, 0, 1'b0, 1'b0);
    issue(enc_ri(5'd4, 5'd1, vtb(0, 0, 3'b000, 3'b100)), 32'd6, 32'h0);
    expect_all("R5 lmul 100", VILL, 0, 1'b0, 1'b0);
    issue(enc_ri(5'd4, 5'd1, 8'h00) | 32'h1000_0000, 32'd6, 32'h0);
    expect_all("R5 reserved imm bit", VILL, 0, 1'b0, 1'b0);
  endtask

  task automatic t_regvt;
    issue(enc_rr(5'd6, 5'd3), 32'd5, 32'h0000_00D0);
    expect_all("R3 reg type e32 m1 avl5", 32'hD0, 3, 1'b1, 1'b1);
    issue(enc_rr(5'd6, 5'd3), 32'd5, 32'h0000_0100);
    expect_all("R5 rs2 reserved bit8", VILL, 0, 1'b0, 1'b0);
    issue(enc_rr(5'd6, 5'd3), 32'd5, 32'h8000_0000);
    expect_all("R5 rs2 msb", VILL, 0, 1'b0, 1'b0);
  endtask

  task automatic t_immavl;
    issue(enc_ii(5'd7, 5'd31, vtb(0, 0, 3'b000, 3'b011)), 32'd0, 32'h0);
    expect_all("R9 uimm31 e8 m8", 32'h03, 31, 1'b1, 1'b1);
    issue(enc_ii(5'd7, 5'd3, vtb(0, 0, 3'b011, 3'b000)), 32'd0, 32'h0);
    expect_all("R9 uimm3 vlmax2", 32'h18, 2, 1'b1, 1'b1);
    issue(enc_ii(5'd7, 5'd4, vtb(0, 0, 3'b011, 3'b000)), 32'd0, 32'h0);
    expect_all("R9 uimm4 vlmax2", 32'h18, 2, 1'b1, 1'b1);
    issue(enc_ii(5'd7, 5'd1, vtb(0, 0, 3'b011, 3'b000)), 32'd0, 32'h0);
    expect_all("R9 uimm1", 32'h18, 1, 1'b1, 1'b1);
    issue(enc_ii(5'd7, 5'd0, vtb(0, 0, 3'b011, 3'b000)), 32'd0, 32'h0);
    expect_all("R9 uimm0", 32'h18, 0, 1'b1, 1'b1);
    chk("R10 rd_data uimm0", rd_data_o, 0);
  endtask

  task automatic t_idle;
    issue(enc_ii(5'd7, 5'd9, 8'h00), 32'd0, 32'h0);
    expect_all("R12 setup", 32'h00, 9, 1'b1, 1'b1);
    @(negedge clk);
    instr_i = enc_ii(5'd7, 5'd20, 8'h03); valid_i = 1'b0;
    @(negedge clk);
    expect_all("R12 strobe low", 32'h00, 9, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_decode();
    t_avl_rule();
    t_vlmax();
    t_keep();
    t_illegal();
    t_regvt();
    t_immavl();
    t_idle();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule